// File: doc/BRIEF.md
# Oldest-First Reservation Station for an Integer Unit

This block holds renamed integer instructions that are waiting for one fully pipelined functional unit, such as an adder or a multiplier, in a dataflow-scheduled core. The in-order issue logic gives it an instruction in which each source is either a value or the tag of the instruction that will produce it. The second source may also be an immediate, which arrives marked ready. The issue request gets its accept or reject answer in the same cycle, together with the tag given to the new entry.

Two completion buses are watched at the same time, one from the adder and one from the multiplier. Any waiting source whose tag matches a valid bus captures that value. In each cycle, at most one entry whose sources are both ready goes to the unit with its tag and both operand values. When several entries are ready, the oldest one goes first, whatever slot it occupies.

Within a cycle the order is completion, then dispatch, then issue. A source woken by a bus can therefore dispatch in that same cycle. A slot freed by this cycle's dispatch can take this cycle's issue. A newly issued instruction dispatches one cycle later at the earliest.

Top module: `rs_station`

## Requirements
- R1: After reset, or while reset is low, all slots are empty, `st_idle` is 1 and `disp_valid` is 0.
- R2: `iss_accept` is high in the same cycle as `iss_valid` when a slot is free or is being freed by this cycle's dispatch. Otherwise it is 0, and it is always 0 without `iss_valid`.
- R3: The tag given at issue is `{UNIT, zero padding, slot index}`, with the unit bit in bit TAG_W-1 (0 = adder, 1 = multiplier) and the slot index in bits IDX_W-1:0. The slot is the lowest-numbered free slot, and a slot freed by dispatch counts as free in that cycle.
- R4: When more than one entry is ready, the entry that was issued earliest dispatches, independent of slot number.
- R5: At most one entry dispatches per cycle. `disp_tag`, `disp_op1` and `disp_op2` carry that entry's tag and operand values, and the slot is freed by the dispatch.
- R6: A waiting source captures the value from either bus when that bus is valid and its tag equals the source tag. Both buses are taken in the same cycle. A bus with valid low, or with a different tag, leaves the source waiting.
- R7: An entry whose last missing source is delivered by a bus in cycle N can dispatch in cycle N.
- R8: A source issued while a bus carries its tag in the same cycle is stored as ready with that value. An instruction accepted in cycle N does not dispatch before cycle N+1.
- R9: A source presented as ready at issue, including an immediate second operand, is stored as given and needs no bus.
- R10: `st_idle` is 1 exactly when no slot holds an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request present |
| iss_src1_tag | input | TAG_W | Producer tag of the first source |
| iss_src1_rdy | input | 1 | First source value already available |
| iss_src1_val | input | DATA_W | First source value |
| iss_src2_tag | input | TAG_W | Producer tag of the second source |
| iss_src2_rdy | input | 1 | Second source available (register value or immediate) |
| iss_src2_val | input | DATA_W | Second source value |
| iss_accept | output | 1 | Request taken this cycle |
| iss_tag | output | TAG_W | Tag given to the accepted instruction |
| add_res_valid | input | 1 | Adder completion bus valid |
| add_res_tag | input | TAG_W | Adder completion tag |
| add_res_val | input | DATA_W | Adder completion value |
| mul_res_valid | input | 1 | Multiplier completion bus valid |
| mul_res_tag | input | TAG_W | Multiplier completion tag |
| mul_res_val | input | DATA_W | Multiplier completion value |
| disp_valid | output | 1 | An entry is sent to the unit this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched entry |
| disp_op1 | output | DATA_W | First operand of the dispatched entry |
| disp_op2 | output | DATA_W | Second operand of the dispatched entry |
| st_idle | output | 1 | No slot is occupied |

## Verification
A table of cycles runs a mix of instructions through the station. Some arrive ready, some carry an immediate, and some wait on one or two tags. The completion buses carry a matching tag, a non-matching tag, or a matching tag with valid low, which separates a correct wakeup from a wakeup that ignores the valid bit or the tag. In one cycle both buses fire together. In another, a bus result and an issue that waits on the same tag land in one cycle, which exposes a missing issue-time capture. A case where the oldest ready entry sits in a higher slot than a younger ready entry separates age order from slot-index priority. A directed fill-to-full sequence checks the reject, and then a single broadcast wakes every entry while the freed slot is refilled in the same cycle, which checks same-cycle slot reuse and drain order.

// File: rtl/rs_pkg.sv
package rs_pkg;
    // Functional unit served by a station; also the top bit of its tags.
    typedef enum logic {
        UNIT_ADD = 1'b0,
        UNIT_MUL = 1'b1
    } unit_e;
endpackage

// File: rtl/rs_operand_snoop.sv
// Resolves one source: keeps a ready value, else takes a matching bus value.
module rs_operand_snoop #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              src_rdy,
    input  logic [TAG_W-1:0]  src_tag,
    input  logic [DATA_W-1:0] src_val,
    input  logic              bus_a_valid,
    input  logic [TAG_W-1:0]  bus_a_tag,
    input  logic [DATA_W-1:0] bus_a_val,
    input  logic              bus_b_valid,
    input  logic [TAG_W-1:0]  bus_b_tag,
    input  logic [DATA_W-1:0] bus_b_val,
    output logic              out_rdy,
    output logic [DATA_W-1:0] out_val
);
    logic hit_a;
    logic hit_b;

    assign hit_a = bus_a_valid && (bus_a_tag == src_tag);
    assign hit_b = bus_b_valid && (bus_b_tag == src_tag);

    always_comb begin
        out_rdy = src_rdy;
        out_val = src_val;
        if (!src_rdy) begin
            if (hit_a) begin
                out_rdy = 1'b1;
                out_val = bus_a_val;
            end else if (hit_b) begin
                out_rdy = 1'b1;
                out_val = bus_b_val;
            end
        end
    end
endmodule

// File: rtl/rs_age_select.sv
// Grants the ready slot that no other ready slot is older than.
// older[j][i] = 1 means slot j was issued before slot i.
module rs_age_select #(
    parameter int N = 4
) (
    input  logic [N-1:0]        ready,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        grant,
    output logic                any
);
    logic [N-1:0][N-1:0] col;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                col[i][j] = older[j][i];
            end
        end
        for (int i = 0; i < N; i++) begin
            grant[i] = ready[i] && !(|(ready & col[i]));
        end
        any = |ready;
    end
endmodule

// File: rtl/rs_free_find.sv
// Lowest-numbered free slot.
module rs_free_find #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     free_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
    parameter int            SLOTS  = 4,
    parameter int            DATA_W = 32,
    parameter int            TAG_W  = 4,
    parameter rs_pkg::unit_e UNIT   = rs_pkg::UNIT_ADD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [TAG_W-1:0]  iss_src1_tag,
    input  logic              iss_src1_rdy,
    input  logic [DATA_W-1:0] iss_src1_val,
    input  logic [TAG_W-1:0]  iss_src2_tag,
    input  logic              iss_src2_rdy,
    input  logic [DATA_W-1:0] iss_src2_val,
    output logic              iss_accept,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              add_res_valid,
    input  logic [TAG_W-1:0]  add_res_tag,
    input  logic [DATA_W-1:0] add_res_val,
    input  logic              mul_res_valid,
    input  logic [TAG_W-1:0]  mul_res_tag,
    input  logic [DATA_W-1:0] mul_res_val,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [DATA_W-1:0] disp_op1,
    output logic [DATA_W-1:0] disp_op2,
    output logic              st_idle
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic              busy;
        logic              r1;
        logic [TAG_W-1:0]  t1;
        logic [DATA_W-1:0] v1;
        logic              r2;
        logic [TAG_W-1:0]  t2;
        logic [DATA_W-1:0] v2;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0]            slot;
        logic  [SLOTS-1:0][SLOTS-1:0] older;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [TAG_W-1:0] slot_tag(input logic [IDX_W-1:0] idx);
        logic [TAG_W-1:0] t;
        t              = '0;
        t[TAG_W-1]     = (UNIT == rs_pkg::UNIT_MUL);
        t[IDX_W-1:0]   = idx;
        return t;
    endfunction

    // Per-slot wakeup against both completion buses
    logic [SLOTS-1:0]             w_r1, w_r2;
    logic [SLOTS-1:0][DATA_W-1:0] w_v1, w_v2;
    logic [SLOTS-1:0]             slot_busy;
    logic [SLOTS-1:0]             slot_ready;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        rs_operand_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop1 (
            .src_rdy    (st_q.slot[g].r1),
            .src_tag    (st_q.slot[g].t1),
            .src_val    (st_q.slot[g].v1),
            .bus_a_valid(add_res_valid),
            .bus_a_tag  (add_res_tag),
            .bus_a_val  (add_res_val),
            .bus_b_valid(mul_res_valid),
            .bus_b_tag  (mul_res_tag),
            .bus_b_val  (mul_res_val),
            .out_rdy    (w_r1[g]),
            .out_val    (w_v1[g])
        );
        rs_operand_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop2 (
            .src_rdy    (st_q.slot[g].r2),
            .src_tag    (st_q.slot[g].t2),
            .src_val    (st_q.slot[g].v2),
            .bus_a_valid(add_res_valid),
            .bus_a_tag  (add_res_tag),
            .bus_a_val  (add_res_val),
            .bus_b_valid(mul_res_valid),
            .bus_b_tag  (mul_res_tag),
            .bus_b_val  (mul_res_val),
            .out_rdy    (w_r2[g]),
            .out_val    (w_v2[g])
        );
        assign slot_busy[g]  = st_q.slot[g].busy;
        assign slot_ready[g] = st_q.slot[g].busy && w_r1[g] && w_r2[g];
    end

    // Issue-time capture from same-cycle broadcasts
    logic              n_r1, n_r2;
    logic [DATA_W-1:0] n_v1, n_v2;

    rs_operand_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_iss_snoop1 (
        .src_rdy    (iss_src1_rdy),
        .src_tag    (iss_src1_tag),
        .src_val    (iss_src1_val),
        .bus_a_valid(add_res_valid),
        .bus_a_tag  (add_res_tag),
        .bus_a_val  (add_res_val),
        .bus_b_valid(mul_res_valid),
        .bus_b_tag  (mul_res_tag),
        .bus_b_val  (mul_res_val),
        .out_rdy    (n_r1),
        .out_val    (n_v1)
    );
    rs_operand_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_iss_snoop2 (
        .src_rdy    (iss_src2_rdy),
        .src_tag    (iss_src2_tag),
        .src_val    (iss_src2_val),
        .bus_a_valid(add_res_valid),
        .bus_a_tag  (add_res_tag),
        .bus_a_val  (add_res_val),
        .bus_b_valid(mul_res_valid),
        .bus_b_tag  (mul_res_tag),
        .bus_b_val  (mul_res_val),
        .out_rdy    (n_r2),
        .out_val    (n_v2)
    );

    // Oldest-ready selection
    logic [SLOTS-1:0] grant;
    logic             any_ready;

    rs_age_select #(.N(SLOTS)) u_pick (
        .ready(slot_ready),
        .older(st_q.older),
        .grant(grant),
        .any  (any_ready)
    );

    // Allocation: a slot dispatched this cycle is free for this cycle's issue
    logic [SLOTS-1:0] free_vec;
    logic             slot_found;
    logic [IDX_W-1:0] alloc_idx;

    assign free_vec = ~slot_busy | grant;

    rs_free_find #(.N(SLOTS), .IDX_W(IDX_W)) u_alloc (
        .free_vec(free_vec),
        .found   (slot_found),
        .idx     (alloc_idx)
    );

    always_comb begin
        // dispatch payload
        disp_valid = any_ready;
        disp_tag   = '0;
        disp_op1   = '0;
        disp_op2   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (grant[i]) begin
                disp_tag = slot_tag(IDX_W'(i));
                disp_op1 = w_v1[i];
                disp_op2 = w_v2[i];
            end
        end

        iss_accept = iss_valid && slot_found;
        iss_tag    = slot_tag(alloc_idx);
        st_idle    = ~|slot_busy;

        // completion, then dispatch
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (st_q.slot[i].busy) begin
                st_d.slot[i].r1 = w_r1[i];
                st_d.slot[i].v1 = w_v1[i];
                st_d.slot[i].r2 = w_r2[i];
                st_d.slot[i].v2 = w_v2[i];
            end
            if (grant[i]) begin
                st_d.slot[i].busy = 1'b0;
            end
        end

        // issue: new entry is younger than everything still held
        if (iss_accept) begin
            st_d.slot[alloc_idx].busy = 1'b1;
            st_d.slot[alloc_idx].r1   = n_r1;
            st_d.slot[alloc_idx].t1   = iss_src1_tag;
            st_d.slot[alloc_idx].v1   = n_v1;
            st_d.slot[alloc_idx].r2   = n_r2;
            st_d.slot[alloc_idx].t2   = iss_src2_tag;
            st_d.slot[alloc_idx].v2   = n_v2;
            for (int j = 0; j < SLOTS; j++) begin
                st_d.older[alloc_idx][j] = 1'b0;
                st_d.older[j][alloc_idx] = (IDX_W'(j) != alloc_idx) && st_d.slot[j].busy;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int            SLOTS = 4,
    parameter int            TAG_W = 4,
    parameter rs_pkg::unit_e UNIT  = rs_pkg::UNIT_ADD
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_accept,
    input logic [TAG_W-1:0] iss_tag,
    input logic             disp_valid,
    input logic [TAG_W-1:0] disp_tag,
    input logic             st_idle,
    input logic [SLOTS-1:0] slot_busy
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [TAG_W-1:0] HI_EXP =
        TAG_W'(UNIT == rs_pkg::UNIT_MUL) << (TAG_W - 1 - IDX_W);

    // R2: no accept without a request
    assert_accept_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> iss_valid);

    // R2: full and nothing leaving means reject
    assert_full_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(slot_busy) == SLOTS) && !disp_valid) |-> !iss_accept);

    // R3: issued tag carries this unit and lands in an occupied slot next cycle
    assert_tag_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> ((iss_tag >> IDX_W) == HI_EXP));
    assert_tag_slot_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |=> slot_busy[$past(iss_tag[IDX_W-1:0])]);

    // R5: dispatch comes from an occupied slot of this unit
    assert_disp_from_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (slot_busy[disp_tag[IDX_W-1:0]] && ((disp_tag >> IDX_W) == HI_EXP)));

    // R8: an accepted instruction occupies the station in the following cycle
    assert_accept_not_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |=> !st_idle);

    // R10: an idle station has nothing to send
    assert_idle_no_disp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !disp_valid);
endmodule

bind rs_station rs_station_chk #(.SLOTS(SLOTS), .TAG_W(TAG_W), .UNIT(UNIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_accept(iss_accept),
    .iss_tag   (iss_tag),
    .disp_valid(disp_valid),
    .disp_tag  (disp_tag),
    .st_idle   (st_idle),
    .slot_busy (slot_busy)
);

// File: tb/rs_station_tb.sv
`timescale 1ns/1ps
module rs_station_tb;
    localparam int SLOTS  = 4;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 4;
    localparam int NV     = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [TAG_W-1:0]  iss_src1_tag = '0;
    logic              iss_src1_rdy = 1'b0;
    logic [DATA_W-1:0] iss_src1_val = '0;
    logic [TAG_W-1:0]  iss_src2_tag = '0;
    logic              iss_src2_rdy = 1'b0;
    logic [DATA_W-1:0] iss_src2_val = '0;
    logic              iss_accept;
    logic [TAG_W-1:0]  iss_tag;
    logic              add_res_valid = 1'b0;
    logic [TAG_W-1:0]  add_res_tag = '0;
    logic [DATA_W-1:0] add_res_val = '0;
    logic              mul_res_valid = 1'b0;
    logic [TAG_W-1:0]  mul_res_tag = '0;
    logic [DATA_W-1:0] mul_res_val = '0;
    logic              disp_valid;
    logic [TAG_W-1:0]  disp_tag;
    logic [DATA_W-1:0] disp_op1;
    logic [DATA_W-1:0] disp_op2;
    logic              st_idle;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rs_station #(.SLOTS(SLOTS), .DATA_W(DATA_W), .TAG_W(TAG_W), .UNIT(rs_pkg::UNIT_MUL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid),
        .iss_src1_tag(iss_src1_tag), .iss_src1_rdy(iss_src1_rdy), .iss_src1_val(iss_src1_val),
        .iss_src2_tag(iss_src2_tag), .iss_src2_rdy(iss_src2_rdy), .iss_src2_val(iss_src2_val),
        .iss_accept(iss_accept), .iss_tag(iss_tag),
        .add_res_valid(add_res_valid), .add_res_tag(add_res_tag), .add_res_val(add_res_val),
        .mul_res_valid(mul_res_valid), .mul_res_tag(mul_res_tag), .mul_res_val(mul_res_val),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op1(disp_op1), .disp_op2(disp_op2),
        .st_idle(st_idle)
    );

    // Row: iv t1 r1 v1 t2 r2 v2 | av at ad | bv bt bd | acc tag | dv dtag op1 op2 | idle
    // Multiplier station: tags are 8 + slot index.
    localparam int VEC [NV][20] = '{
        '{1,2,0,0,  0,1,5,   0,0,0,  0,0,0,  1,8,  0,0,0,0,    1},
        '{1,0,1,10, 0,1,20,  0,0,0,  0,0,0,  1,9,  0,0,0,0,    0},
        '{1,3,0,0,  4,0,0,   0,0,0,  0,0,0,  1,9,  1,9,10,20,  0},
        '{0,0,0,0,  0,0,0,   1,2,7,  1,3,30, 0,0,  1,8,7,5,    0},
        '{1,4,0,0,  0,1,1,   0,0,0,  1,4,40, 1,8,  1,9,30,40,  0},
        '{1,0,1,2,  0,1,3,   0,0,0,  0,0,0,  1,8,  1,8,40,1,   0},
        '{1,5,0,0,  0,1,6,   0,0,0,  0,0,0,  1,8,  1,8,2,3,    0},
        '{1,0,1,11, 0,1,12,  1,6,99, 0,0,0,  1,9,  0,0,0,0,    0},
        '{1,5,0,0,  5,0,0,   0,0,0,  0,5,1,  1,9,  1,9,11,12,  0},
        '{1,0,1,70, 0,1,80,  1,5,50, 0,0,0,  1,8,  1,8,50,6,   0},
        '{0,0,0,0,  0,0,0,   0,0,0,  0,0,0,  0,0,  1,9,50,50,  0},
        '{0,0,0,0,  0,0,0,   0,0,0,  0,0,0,  0,0,  1,8,70,80,  0},
        '{0,0,0,0,  0,0,0,   0,0,0,  0,0,0,  0,0,  0,0,0,0,    1}
    };

    function automatic string vec_label(int k);
        case (k)
            0:  return "R9 R3 first issue with immediate";
            1:  return "R8 no dispatch in issue cycle";
            2:  return "R3 slot reuse on dispatch R5";
            3:  return "R6 both buses in one cycle R7";
            4:  return "R8 capture at issue R7";
            5:  return "R9 ready operands";
            6:  return "R5 payload";
            7:  return "R6 other tag ignored";
            8:  return "R6 invalid bus ignored";
            9:  return "R4 oldest of two ready";
            10: return "R4 oldest in higher slot";
            11: return "R5 last entry";
            default: return "R10 drained";
        endcase
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run(input int r[20], input string lbl);
        @(negedge clk);
        iss_valid     = r[0] != 0;
        iss_src1_tag  = TAG_W'(r[1]);
        iss_src1_rdy  = r[2] != 0;
        iss_src1_val  = DATA_W'(r[3]);
        iss_src2_tag  = TAG_W'(r[4]);
        iss_src2_rdy  = r[5] != 0;
        iss_src2_val  = DATA_W'(r[6]);
        add_res_valid = r[7] != 0;
        add_res_tag   = TAG_W'(r[8]);
        add_res_val   = DATA_W'(r[9]);
        mul_res_valid = r[10] != 0;
        mul_res_tag   = TAG_W'(r[11]);
        mul_res_val   = DATA_W'(r[12]);
        #1;
        chk({lbl, " accept"}, 32'(iss_accept), 32'(r[13]));
        if (r[13] != 0) chk({lbl, " issue tag"}, 32'(iss_tag), 32'(r[14]));
        chk({lbl, " disp_valid"}, 32'(disp_valid), 32'(r[15]));
        if (r[15] != 0) begin
            chk({lbl, " disp_tag"}, 32'(disp_tag), 32'(r[16]));
            chk({lbl, " disp_op1"}, 32'(disp_op1), 32'(r[17]));
            chk({lbl, " disp_op2"}, 32'(disp_op2), 32'(r[18]));
        end
        chk({lbl, " idle"}, 32'(st_idle), 32'(r[19]));
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 idle in reset", 32'(st_idle), 32'd1);
        chk("R1 no dispatch in reset", 32'(disp_valid), 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run(VEC[k], vec_label(k));

        // R2: fill all slots with waiting entries, then a fifth is rejected
        for (int q = 0; q < SLOTS; q++)
            run('{1,6,0,0, 0,1,q+1, 0,0,0, 0,0,0, 1,8+q, 0,0,0,0, (q == 0) ? 1 : 0}, "R2 fill");
        run('{1,0,1,9, 0,1,9, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 0}, "R2 full reject");
        // one broadcast wakes all; freed slot 0 refilled in the same cycle
        run('{1,0,1,7, 0,1,8, 0,0,0, 1,6,100, 1,8, 1,8,100,1, 0}, "R2 R3 R7 wake and reuse");
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 1,9,100,2, 0},  "R4 drain order");
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 1,10,100,3, 0}, "R4 drain order");
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 1,11,100,4, 0}, "R4 drain order");
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 1,8,7,8, 0},    "R4 youngest last");
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 1},    "R10 empty again");

        // R1: reset in the middle of operation clears held entries
        run('{1,0,1,1, 0,1,2, 0,0,0, 0,0,0, 1,8, 0,0,0,0, 1}, "R1 load before reset");
        @(negedge clk);
        iss_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 idle after mid reset", 32'(st_idle), 32'd1);
        chk("R1 no dispatch after mid reset", 32'(disp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run('{0,0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 1}, "R1 entry gone");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule